// File: doc/BRIEF.md
# CAN Bus Wakeup Detector

This block watches the receive line of a CAN bus while the controller is asleep and asks the host processor to resume work when bus traffic appears. The receive line is first passed through a two-flop synchronizer. Detection is armed only while the block is in its sleep state. The host enters that state with a one-cycle sleep request. A detected wakeup does three things: it ends the sleep state, it raises a one-cycle wakeup pulse, and it sets a sticky wakeup flag. The host clears the flag by writing a 1 to it.

There are two detection modes. In edge mode, any recessive-to-dominant transition wakes the block. Filter mode is there to reject short glitches on the bus. In this mode a counter counts consecutive dominant samples and restarts on any recessive sample, and a wakeup fires only once the count reaches a programmable minimum. A small configuration register holds two bits: the detection mode and a module clock-source select. The register accepts writes only while the soft-reset input is asserted, and both bits reset to 0. A value of 0 means edge mode and the divided crystal clock.

Top module: `can_wake_detect`

## Requirements
- R1: After reset, sleep_active, wake_flag, wake_pulse, mode_filter and clk_pll_sel are all 0.
- R2: A configuration write (cfg_we high for one cycle) updates mode_filter and clk_pll_sel on the next clock only if soft_rst is 1 during that cycle. If soft_rst is 0, the write leaves both outputs unchanged.
- R3: clk_pll_sel reports the stored clock-source bit: 1 selects the PLL output, 0 selects the crystal clock divided by two.
- R4: A one-cycle sleep_req while the block is awake sets sleep_active on the next clock.
- R5: In edge mode (mode_filter = 0) while asleep, a 1-to-0 change of rx_in (0 is dominant) that is applied before a clock edge makes wake_pulse high after the third clock edge. A line that is already dominant when sleep starts causes no wakeup.
- R6: In filter mode (mode_filter = 1) with minimum M, let E = M, or E = 1 when M is 0. A dominant level that holds for at least E sampled cycles makes wake_pulse high after clock edge 2+E, counted from the first dominant sample.
- R7: In filter mode, dominant runs shorter than E produce no wakeup. A single recessive sample restarts the count, so two short runs do not add up.
- R8: While sleep_active is 0, bus activity produces no wake_pulse and does not set wake_flag.
- R9: A wakeup drives wake_pulse high for exactly one cycle. In that same cycle sleep_active reads 0 and wake_flag reads 1.
- R10: Writing flag_clr = 1 clears wake_flag on the next clock, unless a new wakeup occurs in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | One-cycle request to enter sleep |
| rx_in | input | 1 | Asynchronous CAN receive line, 0 = dominant |
| soft_rst | input | 1 | Soft-reset state; configuration writes are accepted only while this is 1 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wake_filter | input | 1 | Mode bit to write: 1 = filter, 0 = edge |
| cfg_clk_pll | input | 1 | Clock-source bit to write: 1 = PLL, 0 = crystal/2 |
| min_width | input | CNT_W | Minimum dominant width in clock cycles for filter mode |
| flag_clr | input | 1 | Write-1-to-clear strobe for wake_flag |
| wake_pulse | output | 1 | One-cycle wakeup request |
| wake_flag | output | 1 | Sticky wakeup flag |
| sleep_active | output | 1 | Block is asleep and detection is armed |
| mode_filter | output | 1 | Stored detection mode |
| clk_pll_sel | output | 1 | Stored clock-source select |

## Verification
On every cycle, the assertions check the following:
- the wake pulse is one cycle long and is always paired with leaving sleep and a set flag;
- no wake happens unless the block was asleep;
- a wake always follows a dominant synchronized sample (in edge mode, one that was preceded by a recessive sample);
- the configuration holds still outside soft reset;
- the flag clears when the host writes to it.

Only the bench scenarios can show the following:
- the exact latency to wakeup;
- that runs shorter than the programmed minimum are rejected across the whole sweep of minimums and run lengths;
- that split glitches do not accumulate;
- that a line already dominant at sleep entry is ignored in edge mode.

// File: rtl/can_wake_pkg.sv
package can_wake_pkg;
  typedef enum logic {
    WAKE_ON_EDGE  = 1'b0,
    WAKE_ON_WIDTH = 1'b1
  } wake_mode_e;

  typedef enum logic {
    CLK_XTAL_DIV2 = 1'b0,
    CLK_PLL       = 1'b1
  } clk_src_e;

  typedef struct packed {
    clk_src_e   clk_src;
    wake_mode_e mode;
  } wake_cfg_t;

  localparam wake_cfg_t CFG_RESET = '{clk_src: CLK_XTAL_DIV2, mode: WAKE_ON_EDGE};
endpackage

// File: rtl/cwd_sync.sv
module cwd_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RESET_VAL;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[gi] <= RESET_VAL;
          else        chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/cwd_cfg.sv
module cwd_cfg
  import can_wake_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      soft_rst,
  input  logic      we,
  input  logic      filter_d,
  input  logic      pll_d,
  output wake_cfg_t cfg,
  output logic      wr_accept
);
  assign wr_accept = we & soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= CFG_RESET;
    end else if (wr_accept) begin
      cfg.mode    <= wake_mode_e'(filter_d);
      cfg.clk_src <= clk_src_e'(pll_d);
    end
  end
endmodule

// File: rtl/cwd_detect.sv
module cwd_detect
  import can_wake_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_s,
  input  logic             armed,
  input  wake_mode_e       mode,
  input  logic [CNT_W-1:0] min_cnt,
  output logic             edge_seen,
  output logic             width_met,
  output logic             evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] eff_min(input logic [CNT_W-1:0] m);
    return (m == '0) ? CNT_W'(1) : m;
  endfunction

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (c == CNT_MAX) ? c : c + CNT_W'(1);
  endfunction

  logic             rx_prev;
  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] run_now;

  assign run_now   = rx_s ? '0 : sat_inc(run_q);
  assign edge_seen = rx_prev & ~rx_s;
  assign width_met = ~rx_s & (run_now >= eff_min(min_cnt));

  always_comb begin
    unique case (mode)
      WAKE_ON_WIDTH: evt = armed & width_met;
      default:       evt = armed & edge_seen;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_prev <= 1'b1;
      run_q   <= '0;
    end else begin
      rx_prev <= rx_s;
      run_q   <= armed ? run_now : '0;
    end
  end
endmodule

// File: rtl/can_wake_detect.sv
module can_wake_detect
  import can_wake_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic             rx_in,
  input  logic             soft_rst,
  input  logic             cfg_we,
  input  logic             cfg_wake_filter,
  input  logic             cfg_clk_pll,
  input  logic [CNT_W-1:0] min_width,
  input  logic             flag_clr,
  output logic             wake_pulse,
  output logic             wake_flag,
  output logic             sleep_active,
  output logic             mode_filter,
  output logic             clk_pll_sel
);
  wake_cfg_t cfg_q;
  logic      cfg_accept;
  logic      rx_sync;
  logic      edge_seen;
  logic      width_met;
  logic      wake_evt;

  cwd_sync #(.STAGES(SYNC_STGS), .RESET_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (rx_in),
    .q_sync  (rx_sync)
  );

  cwd_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .we        (cfg_we),
    .filter_d  (cfg_wake_filter),
    .pll_d     (cfg_clk_pll),
    .cfg       (cfg_q),
    .wr_accept (cfg_accept)
  );

  cwd_detect #(.CNT_W(CNT_W)) u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_s      (rx_sync),
    .armed     (sleep_active),
    .mode      (cfg_q.mode),
    .min_cnt   (min_width),
    .edge_seen (edge_seen),
    .width_met (width_met),
    .evt       (wake_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_active <= 1'b0;
      wake_pulse   <= 1'b0;
      wake_flag    <= 1'b0;
    end else begin
      wake_pulse <= wake_evt;
      if (wake_evt)                     sleep_active <= 1'b0;
      else if (sleep_req && !sleep_active) sleep_active <= 1'b1;
      if (wake_evt)      wake_flag <= 1'b1;
      else if (flag_clr) wake_flag <= 1'b0;
    end
  end

  assign mode_filter = (cfg_q.mode == WAKE_ON_WIDTH);
  assign clk_pll_sel = (cfg_q.clk_src == CLK_PLL);
endmodule

// File: rtl/can_wake_detect_chk.sv
module can_wake_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep_req,
  input logic soft_rst,
  input logic flag_clr,
  input logic wake_pulse,
  input logic wake_flag,
  input logic sleep_active,
  input logic mode_filter,
  input logic clk_pll_sel,
  input logic rx_sync,
  input logic wake_evt
);
  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  p_pulse_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (!sleep_active && wake_flag));

  p_no_wake_awake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(sleep_active));

  p_sleep_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && !sleep_active) |=> sleep_active);

  p_cfg_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(soft_rst) |-> ($stable(mode_filter) && $stable(clk_pll_sel)));

  p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_flag && flag_clr && !wake_evt) |=> !wake_flag);

  p_filter_dominant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pulse && $past(mode_filter)) |-> !$past(rx_sync));

  p_edge_transition_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pulse && !$past(mode_filter)) |-> (!$past(rx_sync) && $past(rx_sync, 2)));
endmodule

bind can_wake_detect can_wake_detect_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sleep_req    (sleep_req),
  .soft_rst     (soft_rst),
  .flag_clr     (flag_clr),
  .wake_pulse   (wake_pulse),
  .wake_flag    (wake_flag),
  .sleep_active (sleep_active),
  .mode_filter  (mode_filter),
  .clk_pll_sel  (clk_pll_sel),
  .rx_sync      (rx_sync),
  .wake_evt     (wake_evt)
);

// File: tb/tb_can_wake_detect.sv
module tb_can_wake_detect;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sleep_req = 1'b0;
  logic             rx_in = 1'b1;
  logic             soft_rst = 1'b0;
  logic             cfg_we = 1'b0;
  logic             cfg_wake_filter = 1'b0;
  logic             cfg_clk_pll = 1'b0;
  logic [CNT_W-1:0] min_width = '0;
  logic             flag_clr = 1'b0;
  logic             wake_pulse, wake_flag, sleep_active, mode_filter, clk_pll_sel;

  int nvec = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  can_wake_detect #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .rx_in(rx_in),
    .soft_rst(soft_rst), .cfg_we(cfg_we), .cfg_wake_filter(cfg_wake_filter),
    .cfg_clk_pll(cfg_clk_pll), .min_width(min_width), .flag_clr(flag_clr),
    .wake_pulse(wake_pulse), .wake_flag(wake_flag), .sleep_active(sleep_active),
    .mode_filter(mode_filter), .clk_pll_sel(clk_pll_sel)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rx_in = 1'b1; sleep_req = 1'b0; cfg_we = 1'b0;
    flag_clr = 1'b0; soft_rst = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic write_cfg(input bit sr, input bit filt, input bit pll);
    soft_rst = sr; cfg_we = 1'b1; cfg_wake_filter = filt; cfg_clk_pll = pll;
    step(1);
    cfg_we = 1'b0; soft_rst = 1'b0;
  endtask

  task automatic go_sleep();
    sleep_req = 1'b1;
    step(1);
    sleep_req = 1'b0;
  endtask

  // Expected wake latency: edge mode E=1; filter mode E=max(M,1); pulse after edge 2+E.
  task automatic run_pulse(input bit filt, input int m, input int len);
    int eff, first, cnt;
    bit expect_wake;
    do_reset();
    write_cfg(1'b1, filt, 1'b0);
    min_width = CNT_W'(m);
    go_sleep();
    check(sleep_active == 1'b1, "R4", sleep_active, 1);
    step(3);
    eff = filt ? ((m == 0) ? 1 : m) : 1;
    expect_wake = (len >= eff);
    first = -1; cnt = 0;
    rx_in = 1'b0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (wake_pulse) begin
        cnt++;
        if (first < 0) first = k;
      end
      if (k == len) rx_in = 1'b1;
    end
    if (filt) begin
      if (expect_wake) check(first == 2 + eff, "R6", first, 2 + eff);
      else             check(first == -1, "R7", first, -1);
    end else begin
      check(first == 3, "R5", first, 3);
    end
    check(cnt == (expect_wake ? 1 : 0), "R9", cnt, expect_wake ? 1 : 0);
    check(wake_flag == expect_wake, "R9", wake_flag, expect_wake);
    check(sleep_active == !expect_wake, "R9", sleep_active, !expect_wake);
    if (expect_wake) begin
      flag_clr = 1'b1;
      step(1);
      flag_clr = 1'b0;
      check(wake_flag == 1'b0, "R10", wake_flag, 0);
    end
  endtask

  initial begin
    do_reset();
    // R1 reset state
    check({sleep_active, wake_flag, wake_pulse, mode_filter, clk_pll_sel} == 5'b0,
          "R1", {sleep_active, wake_flag, wake_pulse, mode_filter, clk_pll_sel}, 0);

    // R2 writes ignored without soft reset
    write_cfg(1'b0, 1'b1, 1'b1);
    step(1);
    check(mode_filter == 1'b0, "R2", mode_filter, 0);
    check(clk_pll_sel == 1'b0, "R2", clk_pll_sel, 0);
    write_cfg(1'b1, 1'b1, 1'b1);
    check(mode_filter == 1'b1, "R2", mode_filter, 1);
    check(clk_pll_sel == 1'b1, "R3", clk_pll_sel, 1);
    write_cfg(1'b1, 1'b1, 1'b0);
    check(clk_pll_sel == 1'b0, "R3", clk_pll_sel, 0);

    // R8 no detection while awake
    begin
      int seen = 0;
      rx_in = 1'b0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (wake_pulse) seen++;
      end
      rx_in = 1'b1;
      check(seen == 0, "R8", seen, 0);
      check(wake_flag == 1'b0, "R8", wake_flag, 0);
    end

    // R5 dominant before sleep in edge mode: ignored until a new edge
    begin
      int seen = 0;
      do_reset();
      rx_in = 1'b0;
      step(4);
      go_sleep();
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (wake_pulse) seen++;
      end
      check(seen == 0, "R5", seen, 0);
      rx_in = 1'b1;
      step(3);
      rx_in = 1'b0;
      step(3);
      check(wake_pulse == 1'b1, "R5", wake_pulse, 1);
      rx_in = 1'b1;
    end

    // R7 split glitches do not accumulate (M=4: runs 3, gap 1, run 3)
    begin
      int seen = 0;
      do_reset();
      write_cfg(1'b1, 1'b1, 1'b0);
      min_width = CNT_W'(4);
      go_sleep();
      step(3);
      rx_in = 1'b0; step(3);
      rx_in = 1'b1; step(1);
      rx_in = 1'b0; step(3);
      rx_in = 1'b1;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (wake_pulse) seen++;
      end
      check(seen == 0, "R7", seen, 0);
      check(sleep_active == 1'b1, "R7", sleep_active, 1);
    end

    // Sweeps
    for (int len = 1; len <= 3; len++) run_pulse(1'b0, 0, len);
    for (int m = 0; m <= 6; m++)
      for (int len = 1; len <= 8; len++) run_pulse(1'b1, m, len);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nvec++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule